// File: doc/BRIEF.md
# Interval Timer Host Access Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. Control words set each channel's counting mode, its BCD flag and its byte access scheme. They also request a count snapshot, or run a read-back command that snapshots count and status for any subset of the channels in one write.

Data-port writes build 16-bit reload values. A value is written as a low byte only, a high byte only, or a low byte followed by a high byte. The completed value is handed to the counter core as a one-cycle load strobe with the value beside it. Data-port reads return, in a fixed priority, a pending status byte, then a frozen count snapshot, then bytes of the live count. The counter cores themselves sit outside this block. Each core supplies its live count and its output level, and receives the load strobe, the load value, the mode and the BCD flag.

Read data is combinational from the address. A read strobe advances the read state at the clock edge. A write strobe takes priority over a read strobe in the same cycle, and that read is then ignored.

Top module: `timer_host_if`

## Requirements
- R1: After reset every channel uses low-then-high word access, with mode 0, BCD flag 0, no pending snapshot and both byte sequencers at the low byte; no load strobe is active.
- R2: A control-port write whose bits 7:6 are 0 to 2 and whose bits 5:4 are nonzero selects that channel. It stores bits 5:4 as the access scheme (1 low only, 2 high only, 3 low then high), bits 3:1 as the mode and bit 0 as the BCD flag. It also returns both byte sequencers of that channel to the low byte.
- R3: With low-only access a data write loads {8'h00, byte}; with high-only access it loads {byte, 8'h00`}. The load strobe is high for exactly the one cycle after the write edge.
- R4: With word access the first data write only stages the byte, with no strobe. The second write loads {second, first}, and the sequence then restarts at the low byte.
- R5: A control word with bits 5:4 equal to 0 captures that channel's live count as a snapshot. While a snapshot is still unread, later capture requests are ignored.
- R6: A snapshot is read according to the access scheme that was in force when it was taken. Low-only returns the low byte, high-only returns the high byte, and word access returns the low byte and then the high byte. The snapshot is released once all its bytes have been read.
- R7: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 requests a count snapshot, under the rule of R5. Bit 4 at 0 captures a status byte, unless a status byte is already pending for that channel.
- R8: The status byte is {output level, 1'b0, access[1:0], mode[2:0], BCD}. It is taken at the cycle of the read-back command.
- R9: A pending status byte is returned before any count snapshot, and reading it clears it.
- R10: With no snapshot pending, data reads return the live count. Low-only access returns the low byte and high-only access returns the high byte. Word access alternates between the low and the high byte, starting with the low byte.
- R11: A read of address 3 returns 8'hFF and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current address |
| ch_count | input | 48 | Live counts, channel i at bits 16i+15:16i |
| ch_out | input | 3 | Counter output levels |
| ch_load | output | 3 | One-cycle reload strobes |
| ch_load_val | output | 48 | Reload values, channel i at bits 16i+15:16i |
| ch_mode | output | 9 | Modes, channel i at bits 3i+2:3i |
| ch_bcd | output | 3 | BCD flags |

## Verification
The bench targets a snapshot request made while an older snapshot is unread. A design without the capture-once rule would return the newer count. It also targets a read-back that sets status and count for the same channel. A design with the wrong read priority would hand back count bytes before the status byte, or would leave the status pending. The bench rewrites a control word halfway through a word write and reads address 3 halfway through a word read. Sequencers that are not reset, or that move on the wrong strobe, would then pair the wrong bytes. Live counts change every cycle, so a snapshot taken on the wrong edge or a read of the live value in place of the frozen one shows up as a byte mismatch.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    SNAP_NONE = 2'd0,
    SNAP_LO   = 2'd1,
    SNAP_HI   = 2'd2,
    SNAP_WORD = 2'd3
  } snap_t;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic              lvl,
    input acc_t              acc,
    input logic [MODE_W-1:0] mode,
    input logic              bcd
  );
    return {lvl, 1'b0, acc, mode, bcd};
  endfunction
endpackage

// File: rtl/timer_ctrl_decode.sv
module timer_ctrl_decode
  import timer_host_pkg::*;
(
  input  logic              cw_wr,
  input  logic [7:1]        cw,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] cnt_req,
  output logic [NUM_CH-1:0] st_req
);
  logic [SEL_W-1:0] sel;
  logic [1:0]       acc_f;
  logic             is_rb;

  assign sel   = cw[7:6];
  assign acc_f = cw[5:4];
  assign is_rb = (sel == 2'd3);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    logic rb_hit;
    assign hit    = cw_wr && !is_rb && (sel == SEL_W'(i));
    assign rb_hit = cw_wr && is_rb && cw[i+1];
    assign cfg_we[i]  = hit && (acc_f != 2'd0);
    assign cnt_req[i] = (hit && (acc_f == 2'd0)) || (rb_hit && !cw[5]);
    assign st_req[i]  = rb_hit && !cw[4];
  end
endmodule

// File: rtl/timer_chan_port.sv
module timer_chan_port
  import timer_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              cfg_we,
  input  logic              cnt_req,
  input  logic              st_req,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rdata,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  acc_t              acc_q, acc_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              bcd_q, bcd_d;
  logic              wr_hi_q, wr_hi_d;
  logic              rd_hi_q, rd_hi_d;
  logic [BYTE_W-1:0] stage_q, stage_d;
  snap_t             snap_q, snap_d;
  logic [CNT_W-1:0]  snap_val_q, snap_val_d;
  logic              st_pend_q, st_pend_d;
  logic [BYTE_W-1:0] st_val_q, st_val_d;
  logic              load_q, load_d;
  logic [CNT_W-1:0]  load_val_q, load_val_d;
  logic              upd_en;

  assign upd_en = data_wr | data_rd | cfg_we | cnt_req | st_req;

  always_comb begin
    acc_d      = acc_q;
    mode_d     = mode_q;
    bcd_d      = bcd_q;
    wr_hi_d    = wr_hi_q;
    rd_hi_d    = rd_hi_q;
    stage_d    = stage_q;
    snap_d     = snap_q;
    snap_val_d = snap_val_q;
    st_pend_d  = st_pend_q;
    st_val_d   = st_val_q;
    load_d     = 1'b0;
    load_val_d = load_val_q;
    if (cfg_we) begin
      acc_d   = acc_t'(wdata[5:4]);
      mode_d  = wdata[3:1];
      bcd_d   = wdata[0];
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
    end
    if (cnt_req && (snap_q == SNAP_NONE)) begin
      snap_d     = snap_t'(acc_q);
      snap_val_d = live_cnt;
    end
    if (st_req && !st_pend_q) begin
      st_pend_d = 1'b1;
      st_val_d  = pack_status(out_lvl, acc_q, mode_q, bcd_q);
    end
    if (data_wr) begin
      unique case (acc_q)
        ACC_LO: begin
          load_d     = 1'b1;
          load_val_d = {{BYTE_W{1'b0}}, wdata};
        end
        ACC_HI: begin
          load_d     = 1'b1;
          load_val_d = {wdata, {BYTE_W{1'b0}}};
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            stage_d = wdata;
            wr_hi_d = 1'b1;
          end else begin
            load_d     = 1'b1;
            load_val_d = {wdata, stage_q};
            wr_hi_d    = 1'b0;
          end
        end
        default: ;
      endcase
    end
    if (data_rd) begin
      if (st_pend_q) begin
        st_pend_d = 1'b0;
      end else if (snap_q != SNAP_NONE) begin
        snap_d = (snap_q == SNAP_WORD) ? SNAP_HI : SNAP_NONE;
      end else if (acc_q == ACC_WORD) begin
        rd_hi_d = ~rd_hi_q;
      end
    end
  end

  always_comb begin
    if (st_pend_q) begin
      rdata = st_val_q;
    end else begin
      unique case (snap_q)
        SNAP_LO, SNAP_WORD: rdata = snap_val_q[BYTE_W-1:0];
        SNAP_HI:            rdata = snap_val_q[CNT_W-1:BYTE_W];
        default: begin
          if ((acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q))
            rdata = live_cnt[CNT_W-1:BYTE_W];
          else
            rdata = live_cnt[BYTE_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      stage_q    <= '0;
      snap_q     <= SNAP_NONE;
      snap_val_q <= '0;
      st_pend_q  <= 1'b0;
      st_val_q   <= '0;
    end else if (upd_en) begin
      acc_q      <= acc_d;
      mode_q     <= mode_d;
      bcd_q      <= bcd_d;
      wr_hi_q    <= wr_hi_d;
      rd_hi_q    <= rd_hi_d;
      stage_q    <= stage_d;
      snap_q     <= snap_d;
      snap_val_q <= snap_val_d;
      st_pend_q  <= st_pend_d;
      st_val_q   <= st_val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q     <= load_d;
      load_val_q <= load_val_d;
    end
  end

  assign mode     = mode_q;
  assign bcd      = bcd_q;
  assign load     = load_q;
  assign load_val = load_val_q;

  AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> $past(data_wr)); // R3
  AST_WORD_FIRST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (acc_q == ACC_WORD) && !wr_hi_q) |=> !load_q); // R4
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((snap_q != SNAP_NONE) && !data_rd) |=> $stable(snap_val_q)); // R5
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && st_pend_q) |=> (!st_pend_q && $stable(snap_q))); // R9
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr || data_rd || cfg_we || cnt_req || st_req)
      |=> $stable({st_pend_q, snap_q, rd_hi_q, wr_hi_q})); // R11
endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
  import timer_host_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [SEL_W-1:0]         addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  input  logic [NUM_CH-1:0]        ch_out,
  output logic [NUM_CH-1:0]        ch_load,
  output logic [NUM_CH*CNT_W-1:0]  ch_load_val,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd
);
  localparam logic [SEL_W-1:0] CTRL_ADDR = SEL_W'(NUM_CH);

  logic              cw_wr;
  logic [NUM_CH-1:0] cfg_we, cnt_req, st_req;
  logic [BYTE_W-1:0] chan_rdata [NUM_CH];

  assign cw_wr = wr_en && (addr == CTRL_ADDR);

  timer_ctrl_decode u_dec (
    .cw_wr   (cw_wr),
    .cw      (wdata[7:1]),
    .cfg_we  (cfg_we),
    .cnt_req (cnt_req),
    .st_req  (st_req)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic dwr, drd;
    assign dwr = wr_en && (addr == SEL_W'(i));
    assign drd = rd_en && !wr_en && (addr == SEL_W'(i));
    timer_chan_port u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (dwr),
      .data_rd  (drd),
      .cfg_we   (cfg_we[i]),
      .cnt_req  (cnt_req[i]),
      .st_req   (st_req[i]),
      .wdata    (wdata),
      .live_cnt (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl  (ch_out[i]),
      .rdata    (chan_rdata[i]),
      .mode     (ch_mode[i*MODE_W +: MODE_W]),
      .bcd      (ch_bcd[i]),
      .load     (ch_load[i]),
      .load_val (ch_load_val[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    unique case (addr)
      2'd0:    rdata = chan_rdata[0];
      2'd1:    rdata = chan_rdata[1];
      2'd2:    rdata = chan_rdata[2];
      default: rdata = {BYTE_W{1'b1}};
    endcase
  end

  AST_ONE_HOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load)); // R3
endmodule

// File: tb/tb_timer_host_if.sv
module tb_timer_host_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [47:0] ch_count;
  logic [2:0]  ch_out;
  logic [2:0]  ch_load;
  logic [47:0] ch_load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  always #10 clk = ~clk;

  timer_host_if dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_count(ch_count), .ch_out(ch_out),
    .ch_load(ch_load), .ch_load_val(ch_load_val), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd)
  );

  int n_chk = 0;
  int n_err = 0;
  bit run = 0;
  bit done = 0;
  string rd_tag = "R10";

  int live [3];
  int m_acc [3], m_mode [3], m_bcd [3], m_wrhi [3], m_rdhi [3], m_stage [3];
  int m_snap [3], m_snapv [3], m_stp [3], m_stv [3];
  int e_load [3], e_lval [3];
  string e_tag [3];

  assign ch_count = {live[2][15:0], live[1][15:0], live[0][15:0]};
  assign ch_out   = {live[2][9], live[1][9], live[0][9]};

  initial for (int i = 0; i < 3; i++) live[i] = 16'h1357 * (i + 1) & 16'hFFFF;
  always @(negedge clk)
    for (int i = 0; i < 3; i++) live[i] <= (live[i] - (i + 1) * 37) & 16'hFFFF;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    if (a == 3) return 255;
    if (m_stp[a] != 0) return m_stv[a];
    case (m_snap[a])
      1, 3: return m_snapv[a] & 255;
      2:    return (m_snapv[a] >> 8) & 255;
      default: begin
        if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rdhi[a] != 0))
          return (live[a] >> 8) & 255;
        return live[a] & 255;
      end
    endcase
  endfunction

  // Behavioural reference model, advanced on every clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_acc[i] = 3; m_mode[i] = 0; m_bcd[i] = 0; m_wrhi[i] = 0; m_rdhi[i] = 0;
        m_stage[i] = 0; m_snap[i] = 0; m_snapv[i] = 0; m_stp[i] = 0; m_stv[i] = 0;
        e_load[i] = 0; e_lval[i] = 0; e_tag[i] = "R3";
      end
    end else begin
      for (int i = 0; i < 3; i++) e_load[i] = 0;
      if (wr_en && addr == 3) begin
        int sel, acc;
        sel = wdata[7:6]; acc = wdata[5:4];
        if (sel == 3) begin
          for (int i = 0; i < 3; i++) if (wdata[i+1]) begin
            if (!wdata[5] && m_snap[i] == 0) begin m_snap[i] = m_acc[i]; m_snapv[i] = live[i]; end
            if (!wdata[4] && m_stp[i] == 0) begin
              m_stp[i] = 1;
              m_stv[i] = (int'(ch_out[i]) << 7) | (m_acc[i] << 4) | (m_mode[i] << 1) | m_bcd[i];
            end
          end
        end else if (acc == 0) begin
          if (m_snap[sel] == 0) begin m_snap[sel] = m_acc[sel]; m_snapv[sel] = live[sel]; end
        end else begin
          m_acc[sel] = acc; m_mode[sel] = wdata[3:1]; m_bcd[sel] = wdata[0];
          m_wrhi[sel] = 0; m_rdhi[sel] = 0;
        end
      end else if (wr_en) begin
        int c;
        c = addr;
        if (m_acc[c] == 1) begin e_load[c] = 1; e_lval[c] = wdata; e_tag[c] = "R3"; end
        else if (m_acc[c] == 2) begin e_load[c] = 1; e_lval[c] = int'(wdata) << 8; e_tag[c] = "R3"; end
        else if (m_wrhi[c] == 0) begin m_stage[c] = wdata; m_wrhi[c] = 1; end
        else begin
          e_load[c] = 1; e_lval[c] = (int'(wdata) << 8) | m_stage[c]; m_wrhi[c] = 0; e_tag[c] = "R4";
        end
      end else if (rd_en && addr != 3) begin
        int c;
        c = addr;
        if (m_stp[c] != 0) m_stp[c] = 0;
        else if (m_snap[c] != 0) m_snap[c] = (m_snap[c] == 3) ? 2 : 0;
        else if (m_acc[c] == 3) m_rdhi[c] = 1 - m_rdhi[c];
      end
    end
  end

  // Compare outputs against the model on every clock
  always @(negedge clk) begin
    #2;
    if (run && !done) begin
      for (int i = 0; i < 3; i++) begin
        check(e_tag[i], int'(ch_load[i]), e_load[i]);
        if (e_load[i] != 0) check(e_tag[i], int'(ch_load_val[i*16 +: 16]), e_lval[i]);
        check("R2 mode", int'(ch_mode[i*3 +: 3]), m_mode[i]);
        check("R2 bcd", int'(ch_bcd[i]), m_bcd[i]);
      end
      if (rd_en) check(rd_tag, int'(rdata), exp_rd(int'(addr)));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk); rd_en = 1; wr_en = 0; addr = a; rd_tag = tag;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check("R1 load", int'(ch_load), 0);
    check("R1 mode", int'(ch_mode), 0);
    check("R1 bcd", int'(ch_bcd), 0);
    run = 1;
    rd(0, "R1"); rd(0, "R1"); rd(0, "R1");
    // low-only channel 0, mode 2
    wr(3, 8'h14); wr(0, 8'h5A); wr(0, 8'hA5);
    rd(0, "R10"); rd(0, "R10");
    // high-only channel 1, mode 3, BCD set
    wr(3, 8'h67); wr(1, 8'hC3);
    rd(1, "R10"); rd(1, "R10");
    // word channel 2, mode 4
    wr(3, 8'hB8); wr(2, 8'h34); wr(2, 8'h12);
    rd(2, "R10"); rd(2, "R10"); rd(2, "R10");
    // control rewrite in the middle of a word write and a word read
    wr(2, 8'h77); rd(2, "R10"); wr(3, 8'hB8);
    wr(2, 8'h11); wr(2, 8'h22);
    rd(2, "R2"); rd(2, "R2");
    // snapshot, second request ignored while pending
    wr(3, 8'h80); repeat (4) @(negedge clk); wr(3, 8'h80);
    rd(2, "R5"); rd(2, "R6"); rd(2, "R6"); rd(2, "R10");
    wr(3, 8'h00); rd(0, "R6"); rd(0, "R10");
    wr(3, 8'h40); rd(1, "R6"); rd(1, "R10");
    // read-back of status and count on all channels
    wr(3, 8'hCE);
    rd(0, "R9"); rd(0, "R7"); rd(0, "R10");
    rd(2, "R8"); rd(2, "R7"); rd(2, "R7"); rd(2, "R10");
    rd(1, "R8"); rd(1, "R7");
    // status only, channel 1; re-request after a mode change is ignored
    wr(3, 8'hE4); wr(3, 8'h52); wr(3, 8'hE4);
    rd(1, "R7"); rd(1, "R8");
    wr(3, 8'hE4); rd(1, "R8");
    // address 3 read in the middle of a word read
    rd(2, "R10"); rd(3, "R11"); rd(2, "R11"); rd(3, "R11"); rd(2, "R11");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule